// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block turns a stream of synchronised D+ and D- line samples into received packet bytes. The lines are sampled at eight times the low-speed bit rate of 1.5 Mbit/s. A free-running phase counter picks the centre sample of each bit period. Any change of line state restarts that counter, so the sampling point follows the transmitter. The bit-centre samples are NRZI-decoded. The receiver hunts for the sync pattern, strips stuffed bits and packs the data least significant bit first into bytes.

The packet ends when a single-ended zero (both lines low) is seen at a bit centre. That check runs before the stuffed-bit rule. A packet whose last byte finishes in a long run of ones therefore still ends on its first SE0 bit period, and that period is not taken as a stuffed bit. An SE0 that arrives while no packet is open is reported as keep-alive signalling on its own pulse. CRC, PID decoding and transmit belong to neighbouring blocks.

Top module: `usbls_rx`

## Requirements
- R1: While reset is held and after its release, `byteValid`, `firstByte`, `eopPulse`, `eopFrameErr`, `keepAlive`, `stuffErr` are 0 and `rxByte` is 0. The idle line is J (D+ = 0, D- = 1).
- R2: Line state K is D+ = 1, D- = 0. A bit period whose centre sample has the same D+ level as the previous centre sample decodes as 1, and one with a different level decodes as 0.
- R3: From idle, a packet opens when at least `SYNC_MIN_ZEROS` (default 5) decoded zeros are followed by a one. A one after fewer zeros returns to idle with no byte and no end-of-packet pulse.
- R4: Data bits are packed least significant bit first. Each completed byte appears on `rxByte` with `byteValid` high for exactly one clock.
- R5: `firstByte` is high together with `byteValid` for the first byte after sync, and only for that byte.
- R6: After `STUFF_RUN` (default 6) consecutive ones, the next bit is discarded and not packed. The closing one of the sync counts as the first one of a run.
- R7: If a one arrives where a stuffed zero was required, `stuffErr` pulses for one clock. The packet is then dropped: no further byte and no `eopPulse` are given until an SE0 and a J bit period have passed.
- R8: An SE0 at a bit centre inside a packet gives a one-clock `eopPulse`. This check comes before the stuffed-bit rule, so a packet whose last byte ends in five or six ones delivers that byte and ends on the first SE0 bit period.
- R9: `eopFrameErr` is high with `eopPulse` when the number of data bits received after the last whole byte is not zero, and low otherwise.
- R10: An SE0 at a bit centre while idle gives a one-clock `keepAlive` pulse and no `eopPulse`.
- R11: After an SE0, one J bit period returns the receiver to idle, and the next packet is received normally.
- R12: Every change of line state restarts bit timing. Bit periods alternating between 7 and 9 samples decode correctly when transitions are at most three bit periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8x the bit rate |
| rstN | input | 1 | Active-low asynchronous reset |
| dpIn | input | 1 | Synchronised D+ sample |
| dmIn | input | 1 | Synchronised D- sample |
| rxByte | output | BYTE_W (8) | Last completed data byte |
| byteValid | output | 1 | One-clock strobe for a new byte on `rxByte` |
| firstByte | output | 1 | The byte being strobed is the first after sync |
| eopPulse | output | 1 | One-clock end-of-packet pulse |
| eopFrameErr | output | 1 | Packet ended with a partial byte (valid with `eopPulse`) |
| keepAlive | output | 1 | One-clock pulse for an SE0 seen outside a packet |
| stuffErr | output | 1 | One-clock pulse for a missing stuffed bit |

## Verification
The sharpest case is a final byte ending in five ones with D- already low, and a final byte ending in six ones with no trailing stuffed bit. A receiver that applies unstuffing before the SE0 check would swallow the first SE0 bit period and either miss the packet end or raise a stuffing error. A sweep of every value as the second byte of a packet covers all run lengths across the byte boundary, so a wrong run count shows up as a corrupted or shifted byte. Sync with exactly the minimum and one fewer zeros, a packet with three leftover bits, a bare SE0 from idle and a missing stuffed bit each target one mode. A jittered packet shows whether bit timing really restarts on each edge.

// File: rtl/usbls_rx_pkg.sv
package usbls_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_ABORT,
    ST_WAITJ
  } rxState_e;

  // strobes from control to datapath, at most one per bit centre
  typedef struct packed {
    logic pktStart;
    logic shiftBit;
    logic dropStuff;
  } dpCmd_t;

endpackage

// File: rtl/usbls_rx_bitclk.sv
module usbls_rx_bitclk #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic dpIn,
  input  logic dmIn,
  output logic strobe,
  output logic lineDp,
  output logic lineSe0
);
  localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [PH_W-1:0] CENTRE = PH_W'(OVS / 2);
  localparam logic [PH_W-1:0] LAST   = PH_W'(OVS - 1);

  logic dpQ, dmQ, dpP, dmP;
  logic [PH_W-1:0] phase, curIdx;
  logic edgeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpQ   <= 1'b0;
      dmQ   <= 1'b1;
      dpP   <= 1'b0;
      dmP   <= 1'b1;
      phase <= '0;
    end else begin
      dpQ   <= dpIn;
      dmQ   <= dmIn;
      dpP   <= dpQ;
      dmP   <= dmQ;
      phase <= curIdx;
    end
  end

  // a change of line state makes the current sample index 0 of a new bit
  always_comb begin
    edgeSeen = (dpQ != dpP) || (dmQ != dmP);
    if (edgeSeen)           curIdx = '0;
    else if (phase == LAST) curIdx = '0;
    else                    curIdx = phase + PH_W'(1);
  end

  assign strobe  = (curIdx == CENTRE);
  assign lineDp  = dpQ;
  assign lineSe0 = !dpQ && !dmQ;

  // R12: bit centres never come on adjacent samples
  p_strobe_spacing_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> !strobe);

endmodule

// File: rtl/usbls_rx_dp.sv
module usbls_rx_dp
  import usbls_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  input  logic              lineDp,
  input  dpCmd_t            cmd,
  output logic              bitVal,
  output logic              stuffDue,
  output logic              partial,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteValid,
  output logic              firstByte
);
  localparam int BC_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int OC_W = $clog2(STUFF_RUN + 1);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);
  localparam logic [OC_W-1:0] RUN_MAX  = OC_W'(STUFF_RUN);

  logic              prevLvl;
  logic [BYTE_W-1:0] shReg, nextWord;
  logic [BC_W-1:0]   bitCnt;
  logic [OC_W-1:0]   onesCnt;
  logic              firstPend;

  // NRZI: unchanged level at the bit centre is a one
  assign bitVal   = (lineDp == prevLvl);
  assign nextWord = {bitVal, shReg[BYTE_W-1:1]};
  assign stuffDue = (onesCnt == RUN_MAX);
  assign partial  = (bitCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevLvl <= 1'b0;
    else if (strobe) prevLvl <= lineDp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      bitCnt    <= '0;
      onesCnt   <= '0;
      firstPend <= 1'b0;
      rxByte    <= '0;
      byteValid <= 1'b0;
      firstByte <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      firstByte <= 1'b0;
      if (cmd.pktStart) begin
        bitCnt    <= '0;
        onesCnt   <= OC_W'(1);
        firstPend <= 1'b1;
      end else if (cmd.shiftBit) begin
        shReg   <= nextWord;
        onesCnt <= bitVal ? onesCnt + OC_W'(1) : '0;
        if (bitCnt == LAST_BIT) begin
          bitCnt    <= '0;
          rxByte    <= nextWord;
          byteValid <= 1'b1;
          firstByte <= firstPend;
          firstPend <= 1'b0;
        end else begin
          bitCnt <= bitCnt + BC_W'(1);
        end
      end else if (cmd.dropStuff) begin
        onesCnt <= '0;
      end
    end
  end

  p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  p_first_with_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    firstByte |-> byteValid);
  p_ones_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= RUN_MAX);
  p_drop_no_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dropStuff |=> (!byteValid && $stable(bitCnt)));

endmodule

// File: rtl/usbls_rx_ctrl.sv
module usbls_rx_ctrl
  import usbls_rx_pkg::*;
#(
  parameter int SYNC_MIN_ZEROS = 5
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   strobe,
  input  logic   se0,
  input  logic   bitVal,
  input  logic   stuffDue,
  input  logic   partial,
  output dpCmd_t cmd,
  output logic   eopPulse,
  output logic   eopFrameErr,
  output logic   keepAlive,
  output logic   stuffErr
);
  localparam int ZC_W = $clog2(SYNC_MIN_ZEROS + 1);
  localparam logic [ZC_W-1:0] ZMIN = ZC_W'(SYNC_MIN_ZEROS);

  rxState_e        state, stateNx;
  logic [ZC_W-1:0] zeroCnt, zeroNx;
  logic            eopNx, feNx, kaNx, seNx;

  always_comb begin
    stateNx = state;
    zeroNx  = zeroCnt;
    cmd     = '0;
    eopNx   = 1'b0;
    feNx    = 1'b0;
    kaNx    = 1'b0;
    seNx    = 1'b0;
    if (strobe) begin
      case (state)
        ST_IDLE: begin
          if (se0) begin
            kaNx    = 1'b1;
            stateNx = ST_WAITJ;
          end else if (!bitVal) begin
            zeroNx  = ZC_W'(1);
            stateNx = ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (se0) begin
            stateNx = ST_WAITJ;
          end else if (!bitVal) begin
            if (zeroCnt != ZMIN) zeroNx = zeroCnt + ZC_W'(1);
          end else if (zeroCnt == ZMIN) begin
            cmd.pktStart = 1'b1;
            stateNx      = ST_DATA;
          end else begin
            stateNx = ST_IDLE;
          end
        end
        ST_DATA: begin
          // line end wins over the stuffed-bit rule
          if (se0) begin
            eopNx   = 1'b1;
            feNx    = partial;
            stateNx = ST_WAITJ;
          end else if (stuffDue) begin
            if (bitVal) begin
              seNx    = 1'b1;
              stateNx = ST_ABORT;
            end else begin
              cmd.dropStuff = 1'b1;
            end
          end else begin
            cmd.shiftBit = 1'b1;
          end
        end
        ST_ABORT: begin
          if (se0) stateNx = ST_WAITJ;
        end
        ST_WAITJ: begin
          if (!se0) stateNx = ST_IDLE;
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      zeroCnt     <= '0;
      eopPulse    <= 1'b0;
      eopFrameErr <= 1'b0;
      keepAlive   <= 1'b0;
      stuffErr    <= 1'b0;
    end else begin
      state       <= stateNx;
      zeroCnt     <= zeroNx;
      eopPulse    <= eopNx;
      eopFrameErr <= feNx;
      keepAlive   <= kaNx;
      stuffErr    <= seNx;
    end
  end

  p_sync_closed_by_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(strobe && bitVal && !se0));
  p_stuff_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    stuffErr |-> (state == ST_ABORT));
  p_eop_on_se0_r8: assert property (@(posedge clk) disable iff (!rstN)
    eopPulse |-> $past(strobe && se0));
  p_fe_only_with_eop_r9: assert property (@(posedge clk) disable iff (!rstN)
    eopFrameErr |-> eopPulse);
  p_ka_from_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    keepAlive |-> ($past(state) == ST_IDLE && !eopPulse));
  p_waitj_exit_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_WAITJ) |-> $past(strobe && !se0));

endmodule

// File: rtl/usbls_rx.sv
module usbls_rx
  import usbls_rx_pkg::*;
#(
  parameter int OVS            = 8,
  parameter int BYTE_W         = 8,
  parameter int STUFF_RUN      = 6,
  parameter int SYNC_MIN_ZEROS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteValid,
  output logic              firstByte,
  output logic              eopPulse,
  output logic              eopFrameErr,
  output logic              keepAlive,
  output logic              stuffErr
);
  logic   strobe, lineDp, lineSe0;
  logic   bitVal, stuffDue, partial;
  dpCmd_t cmd;

  usbls_rx_bitclk #(.OVS(OVS)) uBitClk (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn),
    .strobe(strobe), .lineDp(lineDp), .lineSe0(lineSe0)
  );

  usbls_rx_ctrl #(.SYNC_MIN_ZEROS(SYNC_MIN_ZEROS)) uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .se0(lineSe0),
    .bitVal(bitVal), .stuffDue(stuffDue), .partial(partial), .cmd(cmd),
    .eopPulse(eopPulse), .eopFrameErr(eopFrameErr),
    .keepAlive(keepAlive), .stuffErr(stuffErr)
  );

  usbls_rx_dp #(.BYTE_W(BYTE_W), .STUFF_RUN(STUFF_RUN)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineDp(lineDp), .cmd(cmd),
    .bitVal(bitVal), .stuffDue(stuffDue), .partial(partial),
    .rxByte(rxByte), .byteValid(byteValid), .firstByte(firstByte)
  );

endmodule

// File: tb/tb_usbls_rx.sv
module tb_usbls_rx;
  localparam int OVS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dpIn = 1'b0;
  logic dmIn = 1'b1;
  logic [7:0] rxByte;
  logic byteValid, firstByte, eopPulse, eopFrameErr, keepAlive, stuffErr;

  always #2 clk = ~clk;

  usbls_rx dut (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn),
    .rxByte(rxByte), .byteValid(byteValid), .firstByte(firstByte),
    .eopPulse(eopPulse), .eopFrameErr(eopFrameErr),
    .keepAlive(keepAlive), .stuffErr(stuffErr)
  );

  int nChk = 0;
  int nFail = 0;
  int rxCnt, firstMask, eopCnt, feCnt, kaCnt, seCnt;
  logic [7:0] rxBuf [16];
  logic [7:0] pkt [8];
  bit bitList [96];
  logic curK = 1'b0;
  bit jitOn = 1'b0;
  bit jitAlt = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        if (rxCnt < 16) rxBuf[rxCnt] = rxByte;
        if (firstByte) firstMask = firstMask | (1 << rxCnt);
        rxCnt = rxCnt + 1;
      end
      if (eopPulse) begin
        eopCnt = eopCnt + 1;
        if (eopFrameErr) feCnt = feCnt + 1;
      end
      if (keepAlive) kaCnt = kaCnt + 1;
      if (stuffErr) seCnt = seCnt + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    nChk = nChk + 1;
    if (act != exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    rxCnt = 0; firstMask = 0; eopCnt = 0; feCnt = 0; kaCnt = 0; seCnt = 0;
    for (int i = 0; i < 16; i++) rxBuf[i] = 8'h00;
  endtask

  task automatic drive(logic dp, logic dm, int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      dpIn = dp;
      dmIn = dm;
    end
  endtask

  task automatic sendBit(bit b);
    int len;
    if (!b) curK = !curK;
    len = jitOn ? (jitAlt ? 9 : 7) : OVS;
    jitAlt = !jitAlt;
    drive(curK, !curK, len);
  endtask

  task automatic idleBits(int n);
    curK = 1'b0;
    drive(1'b0, 1'b1, n * OVS);
  endtask

  // sync, data with optional stuffing, SE0 for two bits, then J idle
  task automatic sendPacket(int nB, int syncZeros, bit doStuff, bit tailStuff,
                            int nExtra, logic [7:0] extraVal);
    int nBits = 0;
    int run;
    for (int i = 0; i < nB; i++)
      for (int k = 0; k < 8; k++) begin bitList[nBits] = pkt[i][k]; nBits++; end
    for (int k = 0; k < nExtra; k++) begin bitList[nBits] = extraVal[k]; nBits++; end
    repeat (syncZeros) sendBit(1'b0);
    sendBit(1'b1);
    run = 1;
    for (int j = 0; j < nBits; j++) begin
      sendBit(bitList[j]);
      run = bitList[j] ? run + 1 : 0;
      if (doStuff && run == 6 && (j < nBits - 1 || tailStuff)) begin
        sendBit(1'b0);
        run = 0;
      end
    end
    drive(1'b0, 1'b0, 2 * OVS);
    idleBits(4);
  endtask

  initial begin
    #800000;
    nFail = nFail + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nChk + 1 - nFail, nChk + 1);
    $finish;
  end

  initial begin
    clearMon();
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 outputs in reset", int'({byteValid, firstByte, eopPulse, eopFrameErr,
          keepAlive, stuffErr, rxByte}), 0);
    @(posedge clk); #1; rstN = 1'b1;
    idleBits(12);
    check("R1 outputs after reset", int'({byteValid, firstByte, eopPulse, eopFrameErr,
          keepAlive, stuffErr, rxByte}), 0);
    check("R10 idle J gives no pulse", rxCnt + eopCnt + kaCnt + seCnt, 0);

    // R2 R4 R5 R8 R9: plain three-byte packet
    clearMon();
    pkt[0] = 8'hA5; pkt[1] = 8'h3C; pkt[2] = 8'h00;
    sendPacket(3, 7, 1'b1, 1'b1, 0, 8'h00);
    check("R2 R4 byte count", rxCnt, 3);
    check("R4 byte0", int'(rxBuf[0]), 'hA5);
    check("R4 byte1", int'(rxBuf[1]), 'h3C);
    check("R4 byte2", int'(rxBuf[2]), 'h00);
    check("R5 first-byte mask", firstMask, 1);
    check("R8 eop count", eopCnt, 1);
    check("R9 no frame error", feCnt, 0);

    // R4 R6: every value as second byte, all run lengths across the boundary
    for (int v = 0; v < 256; v++) begin
      clearMon();
      pkt[0] = 8'hC3; pkt[1] = v[7:0];
      sendPacket(2, 7, 1'b1, 1'b1, 0, 8'h00);
      check("R6 sweep byte value", int'(rxBuf[1]), v);
      check("R4 sweep framing", int'(rxCnt == 2 && eopCnt == 1 && feCnt == 0 &&
            seCnt == 0 && firstMask == 1 && rxBuf[0] == 8'hC3), 1);
    end

    // R6: sync's closing one starts the run
    clearMon();
    pkt[0] = 8'hFF;
    sendPacket(1, 7, 1'b1, 1'b1, 0, 8'h00);
    check("R6 all-ones byte", int'(rxBuf[0]), 'hFF);
    check("R6 no stuff error", seCnt, 0);

    // R8: five ones then SE0, line left at J
    clearMon();
    pkt[0] = 8'hF8;
    sendPacket(1, 7, 1'b1, 1'b1, 0, 8'h00);
    check("R8 five ones, D- high", int'(rxCnt == 1 && rxBuf[0] == 8'hF8 &&
          eopCnt == 1 && seCnt == 0), 1);
    // R8: five ones then SE0 with line at K (D- low from earlier data)
    clearMon();
    pkt[0] = 8'hF8; pkt[1] = 8'hF8;
    sendPacket(2, 7, 1'b1, 1'b1, 0, 8'h00);
    check("R8 five ones, D- low", int'(rxCnt == 2 && rxBuf[1] == 8'hF8 &&
          eopCnt == 1 && feCnt == 0 && seCnt == 0), 1);
    // R8: six ones, SE0 where a stuffed bit was due
    clearMon();
    pkt[0] = 8'hFC;
    sendPacket(1, 7, 1'b1, 1'b0, 0, 8'h00);
    check("R8 six ones no tail stuff", int'(rxCnt == 1 && rxBuf[0] == 8'hFC &&
          eopCnt == 1 && feCnt == 0 && seCnt == 0), 1);
    clearMon();
    sendPacket(1, 7, 1'b1, 1'b1, 0, 8'h00);
    check("R8 six ones with tail stuff", int'(rxCnt == 1 && rxBuf[0] == 8'hFC &&
          eopCnt == 1 && feCnt == 0), 1);

    // R7: missing stuffed bit
    clearMon();
    pkt[0] = 8'h00; pkt[1] = 8'hFF; pkt[2] = 8'h12;
    sendPacket(3, 7, 1'b0, 1'b0, 0, 8'h00);
    check("R7 stuff error pulse", seCnt, 1);
    check("R7 bytes before abort", rxCnt, 1);
    check("R7 no eop after abort", eopCnt, 0);
    // R11: next packet after abort
    clearMon();
    pkt[0] = 8'h2D;
    sendPacket(1, 7, 1'b1, 1'b1, 0, 8'h00);
    check("R11 packet after abort", int'(rxCnt == 1 && rxBuf[0] == 8'h2D &&
          eopCnt == 1 && firstMask == 1), 1);

    // R9: three leftover bits
    clearMon();
    pkt[0] = 8'h5A;
    sendPacket(1, 7, 1'b1, 1'b1, 3, 8'h02);
    check("R9 partial byte flagged", feCnt, 1);
    check("R9 whole byte kept", int'(rxCnt == 1 && rxBuf[0] == 8'h5A && eopCnt == 1), 1);

    // R10: bare SE0 from idle
    clearMon();
    drive(1'b0, 1'b0, 2 * OVS);
    idleBits(4);
    check("R10 keep-alive pulse", kaCnt, 1);
    check("R10 no eop on keep-alive", eopCnt + rxCnt, 0);
    clearMon();
    pkt[0] = 8'h69;
    sendPacket(1, 7, 1'b1, 1'b1, 0, 8'h00);
    check("R11 packet after keep-alive", int'(rxCnt == 1 && rxBuf[0] == 8'h69 &&
          eopCnt == 1 && kaCnt == 0), 1);

    // R3: sync boundary
    clearMon();
    pkt[0] = 8'h96;
    sendPacket(1, 5, 1'b1, 1'b1, 0, 8'h00);
    check("R3 minimum sync accepted", int'(rxCnt == 1 && rxBuf[0] == 8'h96 && eopCnt == 1), 1);
    clearMon();
    sendPacket(1, 4, 1'b1, 1'b1, 0, 8'h00);
    check("R3 short sync rejected", rxCnt + eopCnt, 0);

    // R12: bit periods of 7 and 9 samples
    clearMon();
    pkt[0] = 8'h55; pkt[1] = 8'hAA; pkt[2] = 8'h66;
    jitOn = 1'b1;
    sendPacket(3, 7, 1'b1, 1'b1, 0, 8'h00);
    jitOn = 1'b0;
    check("R12 jittered bytes", int'(rxCnt == 3 && rxBuf[0] == 8'h55 &&
          rxBuf[1] == 8'hAA && rxBuf[2] == 8'h66), 1);
    check("R12 jittered eop", int'(eopCnt == 1 && feCnt == 0 && seCnt == 0), 1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule